// File: doc/BRIEF.md
# Serial Controller Configuration Header

This block answers configuration accesses for a simple communication controller that offers one or two 8-byte I/O windows. An access names a dword index into a 256-byte type-0 header. The block returns the fixed identity and class fields and keeps the base address registers for the I/O windows. It supports the usual probe in which software writes all ones to a base register and reads back its size mask. It also keeps a software-owned interrupt line byte. Everything else in the header either reads as a constant or reads as zero.

A static parameter sets the number of serial ports, either one or two. Port 0 always owns the first base register. The second base register is live only in the two-port build. Reads answer one cycle after they are accepted. Writes take effect on the accepting edge and produce no response.

Top module: `cfg_space_resp`

## Requirements
- R1: Dword 0 (offset 0x00) and dword 11 (offset 0x2C) both read 0x32534348, and writes to them do not change them.
- R2: Dword 1 (offset 0x04) reads 0x02000001: command value 0x0001 in bits 15:0 and status value 0x0200 in bits 31:16. Writes to it are discarded.
- R3: Dword 2 (offset 0x08) reads 0x07000210. The revision 0x10 is in bits 7:0, the interface code 0x02 in bits 15:8, the subclass 0x00 in bits 23:16 and the base class 0x07 in bits 31:24.
- R4: After reset, dword 4 (first base register, offset 0x10) reads 0x00000001. Dword 5 (second base register, offset 0x14) reads the same in the two-port build.
- R5: A write of 0xFFFFFFFF to a live base register stores 0xFFFFFFF8 OR'd with that register's previous bits 1:0. This is 0xFFFFFFF9 straight after reset.
- R6: Any other write to a live base register stores the written word, with bits 1:0 OR'd with the register's previous bits 1:0.
- R7: In the one-port build, dword 5 always reads zero, whatever is written to it.
- R8: Dwords 6, 7 and 8 (offsets 0x18, 0x1C, 0x20) read zero after any write.
- R9: At dword 15 (offset 0x3C), bits 7:0 hold the interrupt line and reset to 0. A write stores wdata[7:0] there. Bits 15:8 always read 0x01, and bits 31:16 always read zero.
- R10: Dword 13 (offset 0x34) and every dword not named above read zero, and writes to them have no effect.
- R11: rsp_valid is high exactly in the cycle after a read is accepted. It carries the value the header held when the read was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dw | input | 6 | Dword index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
Dword 15 is the one place where a single write touches a stored field and a write-protected field at once. The interrupt line byte must update while the pin byte and the upper half keep their fixed values. The bench writes a word with every byte non-zero there and expects the line byte alone to change. Base register writes mix the same two concerns inside one dword, since new address bits arrive while the type bits must persist. Writes whose low bits are non-zero, placed before and after a sizing probe, show whether the type bit survives both paths.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int unsigned DW_W = 6;

  localparam logic [DW_W-1:0] DW_IDENT = 6'd0;
  localparam logic [DW_W-1:0] DW_CMDST = 6'd1;
  localparam logic [DW_W-1:0] DW_CLASS = 6'd2;
  localparam logic [DW_W-1:0] DW_BASE0 = 6'd4;
  localparam logic [DW_W-1:0] DW_SUBID = 6'd11;
  localparam logic [DW_W-1:0] DW_INTR  = 6'd15;

  localparam logic [31:0] IDENT_WORD = 32'h3253_4348;
  localparam logic [15:0] CMD_VAL    = 16'h0001;
  localparam logic [15:0] STS_VAL    = 16'h0200;
  localparam logic [7:0]  REV_VAL    = 8'h10;
  localparam logic [7:0]  PIF_VAL    = 8'h02;
  localparam logic [7:0]  SUB_VAL    = 8'h00;
  localparam logic [7:0]  BCL_VAL    = 8'h07;
  localparam logic [7:0]  PIN_VAL    = 8'h01;
  localparam logic [31:0] IO_RESET   = 32'h0000_0001;

  // size mask of an I/O window: two's complement of its byte size
  function automatic logic [31:0] size_mask(input int unsigned bytes);
    return ~(32'(bytes)) + 32'd1;
  endfunction

  // next base register value on a write
  function automatic logic [31:0] base_next(input logic [31:0] old,
                                            input logic [31:0] wdata,
                                            input logic [31:0] mask);
    logic [31:0] v;
    v = (wdata == 32'hFFFF_FFFF) ? (wdata & mask) : wdata;
    return v | {30'd0, old[1:0]};
  endfunction

  // constant fields of the header, zero elsewhere
  function automatic logic [31:0] fixed_word(input logic [DW_W-1:0] dw);
    case (dw)
      DW_IDENT: return IDENT_WORD;
      DW_SUBID: return IDENT_WORD;
      DW_CMDST: return {STS_VAL, CMD_VAL};
      DW_CLASS: return {BCL_VAL, SUB_VAL, PIF_VAL, REV_VAL};
      default:  return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfgsp_base_reg.sv
module cfgsp_base_reg
  import cfgsp_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 8,
  parameter bit          LIVE      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  localparam logic [31:0] MASK  = size_mask(WIN_BYTES);
  localparam logic [31:0] RST_V = LIVE ? IO_RESET : 32'd0;

  logic [31:0] next_v;
  assign next_v = LIVE ? base_next(q, wdata, MASK) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_V;
    else if (wr_en) q <= next_v;
  end
endmodule

// File: rtl/cfgsp_fixed_rom.sv
module cfgsp_fixed_rom
  import cfgsp_pkg::*;
(
  input  logic [DW_W-1:0] dw,
  output logic [31:0]     data
);
  always_comb data = fixed_word(dw);
endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfgsp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned WIN_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [DW_W-1:0] req_dw,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata
);
  localparam int unsigned NUM_BASE = 2;

  logic                wr_acc, rd_acc;
  logic [NUM_BASE-1:0] base_wr;
  logic [31:0]         base_q [NUM_BASE];
  logic [31:0]         bar0_q, bar1_q;
  logic                line_wr;
  logic [7:0]          line_q;
  logic [31:0]         rom_data, rd_word;

  assign wr_acc  = req_valid &&  req_write;
  assign rd_acc  = req_valid && !req_write;
  assign line_wr = wr_acc && (req_dw == DW_INTR);

  for (genvar i = 0; i < NUM_BASE; i++) begin : g_base
    assign base_wr[i] = wr_acc && (req_dw == DW_BASE0 + DW_W'(i));
    cfgsp_base_reg #(
      .WIN_BYTES(WIN_BYTES),
      .LIVE     (i < NUM_PORTS)
    ) u_base (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(base_wr[i]),
      .wdata(req_wdata),
      .q    (base_q[i])
    );
  end

  assign bar0_q = base_q[0];
  assign bar1_q = base_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= 8'd0;
    else if (line_wr) line_q <= req_wdata[7:0];
  end

  cfgsp_fixed_rom u_rom (.dw(req_dw), .data(rom_data));

  always_comb begin
    case (req_dw)
      DW_BASE0:         rd_word = bar0_q;
      DW_BASE0 + 6'd1:  rd_word = bar1_q;
      DW_INTR:          rd_word = {16'd0, PIN_VAL, line_q};
      default:          rd_word = rom_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker #(
  parameter int unsigned NUM_PORTS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [5:0]  req_dw,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [31:0] bar0_q,
  input logic [31:0] bar1_q
);
  // R11: one response per accepted read, one cycle later
  a_r11_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  // R2: command/status dword is constant on every read of it
  a_r2_cmd_const: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_dw == 6'd1) |=> rsp_rdata == 32'h0200_0001);

  // R9: pin byte and upper half fixed on every read of dword 15
  a_r9_pin_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_dw == 6'd15) |=> rsp_rdata[31:8] == 24'h00_0001);

  // R5: a sizing probe to the first base register leaves the mask bits set
  a_r5_size_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_dw == 6'd4 && req_wdata == 32'hFFFF_FFFF)
      |=> bar0_q[31:3] == 29'h1FFF_FFFF);

  // R6: the I/O type bit of the first base register never drops
  a_r6_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bar0_q[0] == 1'b1);

  // R8: unused base registers read zero
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_dw == 6'd6 || req_dw == 6'd7 || req_dw == 6'd8))
      |=> rsp_rdata == 32'd0);

  if (NUM_PORTS == 1) begin : g_one
    // R7: second base register stays zero in the one-port build
    a_r7_bar1_dead: assert property (@(posedge clk) disable iff (!rst_n)
      bar1_q == 32'd0);
  end else begin : g_two
    // R4: second base register keeps its I/O type bit in the two-port build
    a_r4_bar1_io: assert property (@(posedge clk) disable iff (!rst_n)
      bar1_q[0] == 1'b1);
  end
endmodule

bind cfg_space_resp cfgsp_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_dw   (req_dw),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .bar0_q   (bar0_q),
  .bar1_q   (bar1_q)
);

// File: tb/test_cfg_space_resp.sv
module test_cfg_space_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_dw = 6'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rv2, rv1;
  logic [31:0] rd2, rd1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_space_resp #(.NUM_PORTS(2)) i_cfg_space_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dw(req_dw), .req_wdata(req_wdata), .rsp_valid(rv2), .rsp_rdata(rd2));

  cfg_space_resp #(.NUM_PORTS(1)) i_cfg_space_resp_p1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dw(req_dw), .req_wdata(req_wdata), .rsp_valid(rv1), .rsp_rdata(rd1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] dw, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dw = dw; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // read both builds; response sampled one cycle after acceptance
  task automatic rd(input logic [5:0] dw, input string req,
                    input logic [31:0] exp2, input logic [31:0] exp1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dw = dw;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'd0, rv2 & rv1}, 32'd1);
    check({req, " two-port"}, rd2, exp2);
    check({req, " one-port"}, rd1, exp1);
  endtask

  task automatic t_reset;
    check("R11 idle no rsp", {31'd0, rv2 | rv1}, 32'd0);
    rd(6'd0,  "R1 ident",     32'h3253_4348, 32'h3253_4348);
    rd(6'd11, "R1 subsys",    32'h3253_4348, 32'h3253_4348);
    rd(6'd2,  "R3 class",     32'h0700_0210, 32'h0700_0210);
    rd(6'd4,  "R4 bar0",      32'h0000_0001, 32'h0000_0001);
    rd(6'd5,  "R4 bar1",      32'h0000_0001, 32'h0000_0000);
    rd(6'd15, "R9 intr rst",  32'h0000_0100, 32'h0000_0100);
    rd(6'd13, "R10 cap ptr",  32'h0, 32'h0);
  endtask

  task automatic t_protected;
    wr(6'd1, 32'hFFFF_FFFF);
    rd(6'd1, "R2 cmd/sts", 32'h0200_0001, 32'h0200_0001);
    wr(6'd0, 32'h0);
    wr(6'd11, 32'h1234_5678);
    rd(6'd0,  "R1 ident after wr",  32'h3253_4348, 32'h3253_4348);
    rd(6'd11, "R1 subsys after wr", 32'h3253_4348, 32'h3253_4348);
    wr(6'd13, 32'hDEAD_BEEF);
    wr(6'd30, 32'hDEAD_BEEF);
    rd(6'd13, "R10 cap after wr",  32'h0, 32'h0);
    rd(6'd30, "R10 other after wr", 32'h0, 32'h0);
  endtask

  task automatic t_sizing;
    wr(6'd4, 32'hFFFF_FFFF);
    rd(6'd4, "R5 bar0 size", 32'hFFFF_FFF9, 32'hFFFF_FFF9);
    wr(6'd5, 32'hFFFF_FFFF);
    rd(6'd5, "R5 bar1 size / R7", 32'hFFFF_FFF9, 32'h0);
    wr(6'd4, 32'h0000_C000);
    rd(6'd4, "R6 bar0 addr", 32'h0000_C001, 32'h0000_C001);
    wr(6'd5, 32'h0000_D000);
    rd(6'd5, "R6 bar1 addr / R7", 32'h0000_D001, 32'h0);
    wr(6'd4, 32'h0000_C002);
    rd(6'd4, "R6 low bits or", 32'h0000_C003, 32'h0000_C003);
    wr(6'd4, 32'hFFFF_FFFF);
    rd(6'd4, "R5 size keeps low bits", 32'hFFFF_FFFB, 32'hFFFF_FFFB);
  endtask

  task automatic t_unused_bars;
    for (int k = 6; k <= 8; k++) begin
      wr(6'(k), 32'hFFFF_FFFF);
      rd(6'(k), "R8 unused bar", 32'h0, 32'h0);
    end
  endtask

  task automatic t_intr_line;
    wr(6'd15, 32'hAABB_CC5A);
    rd(6'd15, "R9 line write", 32'h0000_015A, 32'h0000_015A);
    wr(6'd15, 32'h0000_0003);
    rd(6'd15, "R9 line rewrite", 32'h0000_0103, 32'h0000_0103);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dw = 6'd0;
    @(negedge clk);
    check("R11 b2b first", rd2, 32'h3253_4348);
    req_dw = 6'd2;
    @(negedge clk);
    check("R11 b2b second", rd2, 32'h0700_0210);
    req_write = 1'b1; req_dw = 6'd15; req_wdata = 32'h0000_0077;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R11 no rsp after write", {31'd0, rv2}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_protected();
    t_sizing();
    t_unused_bars();
    t_intr_line();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule